// File: doc/BRIEF.md
# Multi-Port Cell Transmit Poller

This block is the cell-layer master of a shared transmit bus that serves up to 32 line ports. A configuration mask chooses which 5-bit port addresses take part. The block cycles through the chosen addresses in rising order. It spends two cycles on each address and reads the single shared cell-available line back from the ports. From the ports that answered "can accept" and that also hold a queued cell, it picks the lowest address. It then presents that address once with the enable high to select the port, and sends a whole cell to it. The cell goes out on a 16-bit bus as 27 words, or on the low byte as 53 bytes.

An upstream source queues cells one write at a time. Each write names a port and gives an 8-bit cell tag. Every port holds up to three tags in arrival order. A write to a full port is thrown away, and that port's discard flags are raised. A cell can be stopped partway through for a set number of cycles. Address polling goes on during the cell and during the stop.

The control is one state machine with four states. **IDLE** polls and waits for a candidate. The transition *grant* goes from IDLE to **SELECT** when at least one candidate exists. SELECT drives the chosen address with the enable high. Polling is frozen for that cycle. The transition *launch* always goes from SELECT to **SEND**. SEND puts out one word per cycle. From SEND, *finish* goes back to IDLE after the last word and removes the cell from its queue. Also from SEND, *stall* goes to **HOLD** when the next word index equals the programmed stop index and the stop length is non-zero. HOLD keeps the enable high, and *resume* returns to SEND after the programmed number of cycles.

Top module: `cell_tx_poller`

## Requirements
- R1: Only addresses whose bit is set in `cfg_active` are selected, and when `cfg_active` is non-zero, every address driven during polling belongs to that set after the first poll slot; a queued cell for an inactive port is never sent.
- R2: Polling drives each active address for exactly two consecutive cycles, moves to the next higher active address, and wraps from the highest back to the lowest.
- R3: `tx_clav` is sampled at the end of the second cycle of an address's poll slot; a port becomes a candidate only if that sample was 1 and its queue is not empty, so a port answering 0 receives no cell.
- R4: When several candidates exist at the moment of a grant, the lowest address is served first.
- R5: In the cycle just before the first word of a cell, `tx_addr` carries the selected port and `tx_enb_n` is 1.
- R6: With `cfg_wide`=1, a cell is 27 words and word k is {tag, k as 8 bits}. With `cfg_wide`=0, a cell is 53 bytes on `tx_data[7:0]`, where byte 0 is the tag, byte k>0 is k, and bits 15:8 are 0.
- R7: `tx_enb_n` is 0 in every cycle that carries a cell word, and `tx_soc` is 1 only with word 0.
- R8: Polling keeps advancing through the active addresses while a cell is being sent and while it is held.
- R9: With `cfg_pause_len`=N>0 and `cfg_pause_at`=P in 1..length-1, exactly P words are sent, then `tx_enb_n` stays 1 for N cycles, then the rest follow. N=0 gives no stop.
- R10: Each port queues at most three cells and sends them in write order. A write to a full port is discarded, even if that port's cell finishes in the same cycle.
- R11: `drop_now[p]` rises in the cycle after a discarded write for port p, and falls when a cell of port p finishes.
- R12: `drop_hist[p]` rises with a discard and stays set until a cycle with `drop_clr`=1 and no new discard for p.
- R13: After reset `tx_enb_n`=1, `tx_soc`=0, both flag vectors are 0, the queues are empty, and polling starts at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_active | input | 32 | One bit per port address taking part in polling |
| cfg_wide | input | 1 | 1: 16-bit words, 27 per cell; 0: bytes, 53 per cell |
| cfg_pause_at | input | 6 | Word index before which a cell stops |
| cfg_pause_len | input | 8 | Stop length in cycles, 0 disables |
| wr_valid | input | 1 | Queue one cell this cycle |
| wr_port | input | 5 | Target port of the write |
| wr_tag | input | 8 | Cell tag written |
| drop_clr | input | 1 | Clears the sticky discard flags |
| tx_clav | input | 1 | Shared cell-available answer from the ports |
| tx_addr | output | 5 | Poll or select address |
| tx_enb_n | output | 1 | Active-low word-valid enable |
| tx_soc | output | 1 | Start-of-cell marker |
| tx_data | output | 16 | Cell word |
| drop_now | output | 32 | Live discard flag per port |
| drop_hist | output | 32 | Sticky discard flag per port |

## Verification
A poll pointer in the wrong place shows on `tx_addr` within one two-cycle slot. It appears as a run longer than two cycles or as a jump out of order. A stale readiness bit or a wrong priority pick shows at the next grant, because a cell then goes to the wrong address or to a port that refused. A corrupted queue slot or count appears at the port when the affected cell is sent: the tag is wrong, the order is wrong, or a cell is missing or extra. The discard flags show any bookkeeping slip one cycle after the write that caused it.

// File: rtl/cell_tx_pkg.sv
package cell_tx_pkg;

    localparam int ADDR_W = 5;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SELECT,
        ST_SEND,
        ST_HOLD
    } tx_state_e;

    // Word k of a cell: wide mode carries tag and index side by side,
    // narrow mode puts the tag in byte 0 and the index in later bytes.
    function automatic logic [15:0] cell_word(input logic wide,
                                              input logic [7:0] tag,
                                              input logic [7:0] idx);
        if (wide) begin
            return {tag, idx};
        end
        if (idx == 8'd0) begin
            return {8'h00, tag};
        end
        return {8'h00, idx};
    endfunction

endpackage

// File: rtl/cell_tx_poll_engine.sv
module cell_tx_poll_engine #(
    parameter int ADDR_W = 5,
    parameter int NP     = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NP-1:0]     active,
    input  logic              stall,
    input  logic              clav,
    input  logic              clr_en,
    input  logic [ADDR_W-1:0] clr_port,
    output logic [ADDR_W-1:0] poll_addr,
    output logic [NP-1:0]     ready
);

    logic [ADDR_W-1:0] cur;
    logic [ADDR_W-1:0] nxt;
    logic [ADDR_W-1:0] probe;
    logic              phase;
    logic [NP-1:0]     ready_d;

    // next higher active address with wrap; stays put when no other exists
    always_comb begin
        nxt   = cur;
        probe = cur;
        for (int k = NP - 1; k >= 1; k--) begin
            probe = cur + ADDR_W'(k);
            if (active[probe]) begin
                nxt = probe;
            end
        end
    end

    always_comb begin
        ready_d = ready & active;
        if (!stall && phase) begin
            ready_d[cur] = clav & active[cur];
        end
        if (clr_en) begin
            ready_d[clr_port] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur   <= '0;
            phase <= 1'b0;
            ready <= '0;
        end else begin
            ready <= ready_d;
            if (stall) begin
                phase <= 1'b0;
            end else if (!phase) begin
                phase <= 1'b1;
            end else begin
                phase <= 1'b0;
                cur   <= nxt;
            end
        end
    end

    assign poll_addr = cur;

endmodule

// File: rtl/cell_tx_port_bufs.sv
module cell_tx_port_bufs #(
    parameter int ADDR_W = 5,
    parameter int DEPTH  = 3,
    parameter int TAG_W  = 8,
    parameter int NP     = 1 << ADDR_W,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_valid,
    input  logic [ADDR_W-1:0]         wr_port,
    input  logic [TAG_W-1:0]          wr_tag,
    input  logic                      pop_en,
    input  logic [ADDR_W-1:0]         pop_port,
    input  logic                      drop_clr,
    output logic [NP-1:0]             has_cell,
    output logic [NP-1:0][TAG_W-1:0]  heads,
    output logic [NP-1:0]             drop_now,
    output logic [NP-1:0]             drop_hist
);

    for (genvar p = 0; p < NP; p++) begin : g_port
        logic [CNT_W-1:0]            cnt;
        logic [DEPTH-1:0][TAG_W-1:0] slot;
        logic                        now_q;
        logic                        hist_q;
        logic                        wr_hit;
        logic                        pop_hit;
        logic                        full;
        logic                        accept;
        logic                        drop;

        assign wr_hit  = wr_valid && (wr_port == ADDR_W'(p));
        assign pop_hit = pop_en && (pop_port == ADDR_W'(p));
        assign full    = (cnt == CNT_W'(DEPTH));
        assign accept  = wr_hit && !full;
        assign drop    = wr_hit && full;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt    <= '0;
                slot   <= '0;
                now_q  <= 1'b0;
                hist_q <= 1'b0;
            end else begin
                if (pop_hit) begin
                    for (int i = 0; i < DEPTH - 1; i++) begin
                        slot[i] <= slot[i+1];
                    end
                end
                if (accept) begin
                    if (pop_hit) begin
                        slot[cnt - CNT_W'(1)] <= wr_tag;
                    end else begin
                        slot[cnt] <= wr_tag;
                    end
                end
                case ({accept, pop_hit})
                    2'b10:   cnt <= cnt + CNT_W'(1);
                    2'b01:   cnt <= cnt - CNT_W'(1);
                    default: cnt <= cnt;
                endcase
                if (drop) begin
                    now_q <= 1'b1;
                end else if (pop_hit) begin
                    now_q <= 1'b0;
                end
                if (drop) begin
                    hist_q <= 1'b1;
                end else if (drop_clr) begin
                    hist_q <= 1'b0;
                end
            end
        end

        assign has_cell[p]  = (cnt != '0);
        assign heads[p]     = slot[0];
        assign drop_now[p]  = now_q;
        assign drop_hist[p] = hist_q;
    end

endmodule

// File: rtl/cell_tx_poller.sv
module cell_tx_poller
    import cell_tx_pkg::*;
#(
    parameter int DEPTH      = 3,
    parameter int PAUSE_W    = 8,
    parameter int WIDE_LEN   = 27,
    parameter int NARROW_LEN = 53
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [31:0]           cfg_active,
    input  logic                  cfg_wide,
    input  logic [5:0]            cfg_pause_at,
    input  logic [PAUSE_W-1:0]    cfg_pause_len,
    input  logic                  wr_valid,
    input  logic [4:0]            wr_port,
    input  logic [7:0]            wr_tag,
    input  logic                  drop_clr,
    input  logic                  tx_clav,
    output logic [4:0]            tx_addr,
    output logic                  tx_enb_n,
    output logic                  tx_soc,
    output logic [15:0]           tx_data,
    output logic [31:0]           drop_now,
    output logic [31:0]           drop_hist
);

    localparam int NP    = 1 << ADDR_W;
    localparam int IDX_W = 6;

    tx_state_e           state;
    logic [ADDR_W-1:0]   sel;
    logic [IDX_W-1:0]    idx;
    logic [IDX_W-1:0]    idx_inc;
    logic [PAUSE_W-1:0]  hold_cnt;
    logic [IDX_W-1:0]    last_idx;
    logic                last_word;

    logic [ADDR_W-1:0]   poll_addr;
    logic [NP-1:0]       ready;
    logic [NP-1:0]       has_cell;
    logic [NP-1:0][7:0]  heads;
    logic [NP-1:0]       cand;
    logic [ADDR_W-1:0]   pick;
    logic                any_cand;

    cell_tx_poll_engine #(.ADDR_W(ADDR_W)) u_poll (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (cfg_active),
        .stall     (state == ST_SELECT),
        .clav      (tx_clav),
        .clr_en    (state == ST_IDLE && any_cand),
        .clr_port  (pick),
        .poll_addr (poll_addr),
        .ready     (ready)
    );

    cell_tx_port_bufs #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .TAG_W(8)) u_bufs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (wr_valid),
        .wr_port   (wr_port),
        .wr_tag    (wr_tag),
        .pop_en    (state == ST_SEND && last_word),
        .pop_port  (sel),
        .drop_clr  (drop_clr),
        .has_cell  (has_cell),
        .heads     (heads),
        .drop_now  (drop_now),
        .drop_hist (drop_hist)
    );

    // lowest-addressed port that answered ready and holds a cell
    always_comb begin
        cand     = ready & has_cell & cfg_active;
        any_cand = |cand;
        pick     = '0;
        for (int k = NP - 1; k >= 0; k--) begin
            if (cand[k]) begin
                pick = ADDR_W'(k);
            end
        end
    end

    assign last_idx  = cfg_wide ? IDX_W'(WIDE_LEN - 1) : IDX_W'(NARROW_LEN - 1);
    assign last_word = (idx == last_idx);
    assign idx_inc   = idx + IDX_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            sel      <= '0;
            idx      <= '0;
            hold_cnt <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (any_cand) begin
                        sel   <= pick;
                        state <= ST_SELECT;
                    end
                end
                ST_SELECT: begin
                    idx   <= '0;
                    state <= ST_SEND;
                end
                ST_SEND: begin
                    if (last_word) begin
                        state <= ST_IDLE;
                    end else begin
                        idx <= idx_inc;
                        if (idx_inc == cfg_pause_at && cfg_pause_len != '0) begin
                            hold_cnt <= cfg_pause_len;
                            state    <= ST_HOLD;
                        end
                    end
                end
                ST_HOLD: begin
                    if (hold_cnt == PAUSE_W'(1)) begin
                        state <= ST_SEND;
                    end else begin
                        hold_cnt <= hold_cnt - PAUSE_W'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        tx_addr  = poll_addr;
        tx_enb_n = 1'b1;
        tx_soc   = 1'b0;
        tx_data  = '0;
        unique case (state)
            ST_IDLE:   ;
            ST_SELECT: tx_addr = sel;
            ST_SEND: begin
                tx_enb_n = 1'b0;
                tx_soc   = (idx == '0);
                tx_data  = cell_word(cfg_wide, heads[sel], 8'(idx));
            end
            ST_HOLD:   ;
            default:   ;
        endcase
    end

endmodule

// File: rtl/cell_tx_poller_chk.sv
module cell_tx_poller_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tx_enb_n,
    input logic        tx_soc,
    input logic        drop_clr,
    input logic [31:0] drop_now,
    input logic [31:0] drop_hist
);

    // R7
    soc_with_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_soc |-> !tx_enb_n);

    // R5
    select_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_soc |-> $past(tx_enb_n));

    // R7
    soc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_soc |=> !tx_soc);

    // R12
    hist_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !drop_clr |=> ((drop_hist & $past(drop_hist)) == $past(drop_hist)));

    // R11
    now_with_hist_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((drop_now & ~$past(drop_now)) & ~drop_hist) == 32'h0);

endmodule

bind cell_tx_poller cell_tx_poller_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_enb_n  (tx_enb_n),
    .tx_soc    (tx_soc),
    .drop_clr  (drop_clr),
    .drop_now  (drop_now),
    .drop_hist (drop_hist)
);

// File: tb/cell_tx_poller_tb.sv
`timescale 1ns/1ps
module cell_tx_poller_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_active = 32'hFFFF_FFFF;
    logic        cfg_wide = 1'b1;
    logic [5:0]  cfg_pause_at = 6'd0;
    logic [7:0]  cfg_pause_len = 8'd0;
    logic        wr_valid = 1'b0;
    logic [4:0]  wr_port = '0;
    logic [7:0]  wr_tag = '0;
    logic        drop_clr = 1'b0;
    logic        tx_clav;
    logic [4:0]  tx_addr;
    logic        tx_enb_n;
    logic        tx_soc;
    logic [15:0] tx_data;
    logic [31:0] drop_now;
    logic [31:0] drop_hist;
    logic [31:0] phy_ok = '0;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    assign tx_clav = phy_ok[tx_addr];

    cell_tx_poller u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_active(cfg_active), .cfg_wide(cfg_wide),
        .cfg_pause_at(cfg_pause_at), .cfg_pause_len(cfg_pause_len),
        .wr_valid(wr_valid), .wr_port(wr_port), .wr_tag(wr_tag), .drop_clr(drop_clr),
        .tx_clav(tx_clav), .tx_addr(tx_addr), .tx_enb_n(tx_enb_n), .tx_soc(tx_soc),
        .tx_data(tx_data), .drop_now(drop_now), .drop_hist(drop_hist)
    );

    // port-side monitor: rebuilds each cell from the bus
    int          n_cells = 0;
    logic [4:0]  log_port [64];
    logic [7:0]  log_tag  [64];
    bit          log_ok   [64];
    int          log_pause[64];
    int          log_pidx [64];
    int          log_moves[64];
    bit          in_cell = 0;
    int          words, pause_n, pidx, moves, exp_len;
    logic [4:0]  cur_port, last_hi_addr, prev_addr;
    logic [7:0]  cur_tag;
    bit          cell_ok, prev_enb_n = 1;
    logic [15:0] mon_exp;

    always @(negedge clk) begin
        if (rst_n) begin
            exp_len = cfg_wide ? 27 : 53;
            if (!tx_enb_n) begin
                if (tx_soc) begin
                    in_cell  = 1;
                    words    = 0;
                    cur_port = last_hi_addr;
                    cur_tag  = cfg_wide ? tx_data[15:8] : tx_data[7:0];
                    cell_ok  = prev_enb_n;
                    pause_n  = 0;
                    pidx     = -1;
                    moves    = 0;
                end
                if (in_cell) begin
                    if (cfg_wide) mon_exp = {cur_tag, 8'(words)};
                    else if (words == 0) mon_exp = {8'h00, cur_tag};
                    else mon_exp = {8'h00, 8'(words)};
                    if (tx_data !== mon_exp) cell_ok = 0;
                    if (tx_soc != (words == 0)) cell_ok = 0;
                    if (tx_addr != prev_addr) moves++;
                    words++;
                    if (words == exp_len) begin
                        log_port[n_cells]  = cur_port;
                        log_tag[n_cells]   = cur_tag;
                        log_ok[n_cells]    = cell_ok;
                        log_pause[n_cells] = pause_n;
                        log_pidx[n_cells]  = pidx;
                        log_moves[n_cells] = moves;
                        n_cells++;
                        in_cell = 0;
                    end
                end
            end else begin
                if (in_cell) begin
                    pause_n++;
                    if (pidx < 0) pidx = words;
                    if (tx_addr != prev_addr) moves++;
                end
                last_hi_addr = tx_addr;
            end
            prev_addr  = tx_addr;
            prev_enb_n = tx_enb_n;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic put_cell(input logic [4:0] port, input logic [7:0] tag);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_port  = port;
        wr_tag   = tag;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic wait_cells(input int target, input string req);
        int t;
        t = 0;
        while (n_cells < target && t < 3000) begin
            @(negedge clk);
            t++;
        end
        chk(n_cells >= target, req, 64'(n_cells), 64'(target));
    endtask

    function automatic logic [4:0] poll_next(input logic [4:0] a);
        if (a == 5'd2) return 5'd5;
        if (a == 5'd5) return 5'd17;
        return 5'd2;
    endfunction

    // {wide, port, tag}
    localparam logic [13:0] VEC [6] = '{
        {1'b1, 5'd3,  8'h31},
        {1'b1, 5'd0,  8'hA0},
        {1'b0, 5'd31, 8'h5F},
        {1'b0, 5'd12, 8'hC4},
        {1'b1, 5'd31, 8'hE7},
        {1'b0, 5'd7,  8'h07}
    };

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", n_cells, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int base;
        logic [4:0] s [16];
        bit seq_ok, in_set;
        int i0;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        chk(tx_enb_n === 1'b1 && tx_soc === 1'b0, "R13 enable/soc", {tx_enb_n, tx_soc}, 2'b10);
        chk(drop_now === '0 && drop_hist === '0, "R13 flags", {drop_now, drop_hist}, 0);
        chk(tx_addr === 5'd0, "R13 poll start", tx_addr, 0);

        // table walk: R6, R5, R7, R8
        for (int v = 0; v < 6; v++) begin
            cfg_wide = VEC[v][13];
            phy_ok   = 32'h1 << VEC[v][12:8];
            base     = n_cells;
            put_cell(VEC[v][12:8], VEC[v][7:0]);
            wait_cells(base + 1, "R6 cell done");
            chk(log_port[base] == VEC[v][12:8], "R5 selected port", log_port[base], VEC[v][12:8]);
            chk(log_tag[base] == VEC[v][7:0], "R6 tag", log_tag[base], VEC[v][7:0]);
            chk(log_ok[base], "R6 R7 word content", 0, 1);
            chk(log_moves[base] >= 4, "R8 polling during cell", log_moves[base], 4);
        end
        cfg_wide = 1'b1;

        // R9 pause inside a cell
        cfg_pause_at  = 6'd5;
        cfg_pause_len = 8'd4;
        phy_ok = 32'h1 << 10;
        base = n_cells;
        put_cell(5'd10, 8'hAA);
        wait_cells(base + 1, "R9 cell done");
        chk(log_pause[base] == 4, "R9 pause length", log_pause[base], 4);
        chk(log_pidx[base] == 5, "R9 pause position", log_pidx[base], 5);
        chk(log_ok[base], "R9 content across pause", 0, 1);
        chk(log_moves[base] >= 4, "R8 polling during pause", log_moves[base], 4);
        cfg_pause_len = 8'd0;

        // R4 lowest address wins after a busy cell
        cfg_active = (32'h1 << 4) | (32'h1 << 9) | (32'h1 << 20);
        phy_ok     = cfg_active;
        base = n_cells;
        put_cell(5'd20, 8'h20);
        for (int t = 0; t < 200 && tx_enb_n; t++) @(negedge clk);
        put_cell(5'd9, 8'h99);
        put_cell(5'd4, 8'h44);
        wait_cells(base + 3, "R4 cells done");
        chk(log_port[base] == 5'd20, "R4 first cell", log_port[base], 20);
        chk(log_port[base+1] == 5'd4 && log_tag[base+1] == 8'h44, "R4 lowest first", log_port[base+1], 4);
        chk(log_port[base+2] == 5'd9 && log_tag[base+2] == 8'h99, "R4 then higher", log_port[base+2], 9);

        // R10 R11 R12 R3 queue depth and discard
        cfg_active = 32'h1 << 6;
        phy_ok = '0;
        base = n_cells;
        put_cell(5'd6, 8'h61);
        put_cell(5'd6, 8'h62);
        put_cell(5'd6, 8'h63);
        chk(drop_now[6] === 1'b0, "R10 three cells fit", drop_now[6], 0);
        put_cell(5'd6, 8'h64);
        chk(drop_now[6] === 1'b1, "R11 live flag on discard", drop_now[6], 1);
        chk(drop_hist[6] === 1'b1, "R12 sticky flag on discard", drop_hist[6], 1);
        repeat (40) @(negedge clk);
        chk(n_cells == base, "R3 refusing port gets nothing", n_cells, base);
        phy_ok = 32'h1 << 6;
        wait_cells(base + 3, "R10 queued cells");
        chk(log_tag[base] == 8'h61 && log_tag[base+1] == 8'h62 && log_tag[base+2] == 8'h63,
            "R10 write order", {log_tag[base], log_tag[base+1], log_tag[base+2]}, 24'h616263);
        repeat (60) @(negedge clk);
        chk(n_cells == base + 3, "R10 dropped cell absent", n_cells, base + 3);
        chk(drop_now[6] === 1'b0, "R11 live flag cleared", drop_now[6], 0);
        chk(drop_hist[6] === 1'b1, "R12 sticky flag kept", drop_hist[6], 1);
        @(negedge clk);
        drop_clr = 1'b1;
        @(negedge clk);
        drop_clr = 1'b0;
        chk(drop_hist === '0, "R12 cleared", drop_hist, 0);

        // R2 R1 poll order over a sparse set
        cfg_active = (32'h1 << 2) | (32'h1 << 5) | (32'h1 << 17);
        phy_ok = '0;
        repeat (8) @(negedge clk);
        for (int k = 0; k < 16; k++) begin
            s[k] = tx_addr;
            @(negedge clk);
        end
        in_set = 1;
        for (int k = 0; k < 16; k++) begin
            if (!(s[k] == 5'd2 || s[k] == 5'd5 || s[k] == 5'd17)) in_set = 0;
        end
        chk(in_set, "R1 only active addresses", 0, 1);
        i0 = 1;
        while (i0 < 15 && s[i0] == s[i0-1]) i0++;
        seq_ok = (i0 <= 2);
        for (int j = i0; j + 2 < 16; j += 2) begin
            if (s[j] != s[j+1] || s[j+2] != poll_next(s[j])) seq_ok = 0;
        end
        chk(seq_ok, "R2 ascending two-cycle slots", {s[0], s[1], s[2], s[3]}, 0);

        // R1 inactive port never served
        phy_ok = 32'h1 << 8;
        base = n_cells;
        put_cell(5'd8, 8'h88);
        repeat (200) @(negedge clk);
        chk(n_cells == base, "R1 inactive port idle", n_cells, base);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule